// File: doc/BRIEF.md
# Byte/Word Selectable ROM Read Port

This block is a synthesizable read port for a 1,572,864 x 16-bit read-only array. The array can also be read as 3,145,728 bytes. A mode input selects the view. In word mode a 21-bit word address picks one 16-bit word, and the whole 16-bit bus is driven. In byte mode an extra least-significant select bit picks either the low or the high byte of that word. The chosen byte is placed on the low lane, and the upper lane stays floating. Three-state pins are modelled by two lane-enable flags. A floating lane reads as zero on the data bus. The top quarter of the word space (address bits 20 and 19 both set) holds no data, and reading there floats both lanes.

Access timing is modelled in clock cycles. One saturating counter tracks how long chip enable, address, mode and select have been steady. A second counter tracks how long output enable has been active. A small state machine turns the two counts into the output state. Its states are:

- `ST_STANDBY`: chip enable is inactive.
- `ST_ADDR_WAIT`: the address is still settling.
- `ST_HOLE`: the address lies in the unpopulated region.
- `ST_OE_WAIT`: the address is settled but output enable has not yet reached its delay.
- `ST_DRIVE`: data is on the bus.

Every clock the next state is chosen from the inputs in this priority order:

1. Chip enable inactive goes to standby.
2. An address count short of `ADDR_LAT` goes to address wait.
3. The unpopulated region goes to hole.
4. An output-enable count short of `OE_LAT` goes to output-enable wait.
5. Otherwise the next state is drive.

The array contents come from a fixed function of the word address, so no memory is stored.

Top module: `rom_rw_port`

## Requirements
- R1: While `rst_n` is low, and at the first check after reset, both lane enables, `dout_valid` and `dout` are 0.
- R2: If `chip_en_n` is 1 at a clock edge, both lane enables and `dout_valid` are 0 after that edge, whatever the other inputs are.
- R3: If `out_en_n` is 1 at a clock edge, both lane enables and `dout_valid` are 0 after that edge.
- R4: In word mode (`word_mode`=1), a driven read sets both lane enables and puts the full 16-bit word on `dout`.
- R5: In byte mode (`word_mode`=0) with `byte_sel`=0, a driven read puts bits 7:0 of the word on `dout[7:0]`. In this case `dout[15:8]` is 0 and `lane_hi_oe` is 0.
- R6: In byte mode with `byte_sel`=1, a driven read puts bits 15:8 of the word on `dout[7:0]`. In this case `dout[15:8]` is 0 and `lane_hi_oe` is 0.
- R7: When `addr[20]` and `addr[19]` are both 1, both lanes float and `dout_valid` is 0 in either mode, even with both enables active.
- R8: Counting the first edge that sees new inputs as 1, outputs are driven after the edge at which two conditions both hold. The first is that `chip_en_n`=0 and the access key have been steady for `ADDR_LAT` edges (default 3). The second is that `chip_en_n`=`out_en_n`=0 for `OE_LAT` edges (default 2).
- R9: A change in address, mode, or (in byte mode) `byte_sel` while chip enable is active restarts the address count at 1. The outputs float from the next edge until `ADDR_LAT` steady edges have passed.
- R10: In word mode `byte_sel` has no effect: toggling it neither restarts the access nor changes `dout`.
- R11: The word at address a is a[15:0] XOR (a[20:16] shifted left by 11) XOR (a[20:16] shifted left by 6) XOR (a[20:16] shifted left by 1) XOR `SEED` (default 16'hA5C3), truncated to 16 bits.
- R12: `dout_valid` equals `lane_lo_oe` at all times, and `dout` is 0 whenever `lane_lo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit word reads, 0 = byte reads |
| addr | input | 21 | Word address |
| byte_sel | input | 1 | Byte select in byte mode (0 low byte, 1 high byte); ignored in word mode |
| dout | output | 16 | Read data; floating lanes read as zero |
| lane_lo_oe | output | 1 | Low lane (bits 7:0) is driven |
| lane_hi_oe | output | 1 | High lane (bits 15:8) is driven |
| dout_valid | output | 1 | Data is stable and at least one lane is driven |

## Verification
Every input reaches the ports within one registered stage, so a wrong count or a wrong state shows at the ports on the very next edge. A counter that restarts or saturates wrongly makes valid appear one or more edges early or late, relative to the steady-input count. A state that ignores chip enable, output enable or the unpopulated region leaves a lane enabled on the edge after that input. A lane selection error shows as wrong data or a wrongly driven upper lane on the first driven cycle. The bench keeps a behavioural count of steady edges and compares every port on every cycle.

// File: rtl/rom_rw_pkg.sv
package rom_rw_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 16;
    localparam int LANE_W = DATA_W / 2;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_ADDR_WAIT,
        ST_HOLE,
        ST_OE_WAIT,
        ST_DRIVE
    } rd_state_e;

    // Fixed contents: low address bits folded with three shifted copies
    // of the top address bits, then a seed.
    function automatic logic [DATA_W-1:0] rom_word(
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] seed
    );
        logic [DATA_W-1:0] fold;
        fold = {a[ADDR_W-1 -: HI_W], a[ADDR_W-1 -: HI_W], a[ADDR_W-1 -: HI_W], 1'b0};
        return a[DATA_W-1:0] ^ fold ^ seed;
    endfunction

endpackage

// File: rtl/rom_lat_counter.sv
module rom_lat_counter #(
    parameter int LIMIT = 3,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          restart,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          full_nxt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    always_comb begin
        if (clear) begin
            cnt_nxt = '0;
        end else if (restart) begin
            cnt_nxt = CNT_ONE;
        end else if (cnt_q < CNT_MAX) begin
            cnt_nxt = cnt_q + CNT_ONE;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    assign full_nxt = (cnt_nxt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R8: the count never passes its limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R9: a restart lands the count on one
    p_restart_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && restart && !clear) |-> (cnt_q == CNT_ONE));

endmodule

// File: rtl/rom_lane_sel.sv
module rom_lane_sel
    import rom_rw_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 16'hA5C3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word_mode,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] lane_data,
    output logic              hi_en
);

    logic [DATA_W-1:0] word;

    assign word = rom_word(addr, SEED);

    always_comb begin
        if (word_mode) begin
            lane_data = word;
            hi_en     = 1'b1;
        end else begin
            lane_data = {{LANE_W{1'b0}},
                         byte_sel ? word[DATA_W-1:LANE_W] : word[LANE_W-1:0]};
            hi_en     = 1'b0;
        end
    end

endmodule

// File: rtl/rom_rw_port.sv
module rom_rw_port
    import rom_rw_pkg::*;
#(
    parameter int                ADDR_LAT = 3,
    parameter int                OE_LAT   = 2,
    parameter logic [DATA_W-1:0] SEED     = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] dout,
    output logic              lane_lo_oe,
    output logic              lane_hi_oe,
    output logic              dout_valid
);

    localparam int KEY_W = ADDR_W + 2;
    localparam int ACW   = $clog2(ADDR_LAT + 1);
    localparam int OCW   = $clog2(OE_LAT + 1);

    logic [KEY_W-1:0]  key_d, key_q;
    logic              restart, hole;
    logic [ACW-1:0]    acc_cnt, acc_nxt;
    logic [OCW-1:0]    oe_cnt, oe_nxt;
    logic              acc_full, oe_full;
    logic [DATA_W-1:0] lane_data, data_q;
    logic              hi_en, hi_q;
    rd_state_e         state_q, state_nxt;

    // access key: byte select only counts in byte mode
    assign key_d   = {word_mode, addr, byte_sel & ~word_mode};
    assign restart = !chip_en_n && (key_d != key_q);
    assign hole    = addr[ADDR_W-1] & addr[ADDR_W-2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            key_q <= key_d;
        end
    end

    rom_lat_counter #(.LIMIT(ADDR_LAT), .CW(ACW)) u_acc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (chip_en_n),
        .restart  (restart),
        .cnt_q    (acc_cnt),
        .cnt_nxt  (acc_nxt),
        .full_nxt (acc_full)
    );

    rom_lat_counter #(.LIMIT(OE_LAT), .CW(OCW)) u_oe_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (chip_en_n | out_en_n),
        .restart  (1'b0),
        .cnt_q    (oe_cnt),
        .cnt_nxt  (oe_nxt),
        .full_nxt (oe_full)
    );

    rom_lane_sel #(.SEED(SEED)) u_lane_sel (
        .addr      (addr),
        .word_mode (word_mode),
        .byte_sel  (byte_sel),
        .lane_data (lane_data),
        .hi_en     (hi_en)
    );

    // next state: priority order standby > address wait > hole > oe wait > drive
    always_comb begin
        if (chip_en_n) begin
            state_nxt = ST_STANDBY;
        end else if (!acc_full) begin
            state_nxt = ST_ADDR_WAIT;
        end else if (hole) begin
            state_nxt = ST_HOLE;
        end else if (!oe_full) begin
            state_nxt = ST_OE_WAIT;
        end else begin
            state_nxt = ST_DRIVE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_nxt;
        end
    end

    // data register, loaded only on entry to or stay in drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            hi_q   <= 1'b0;
        end else if (state_nxt == ST_DRIVE) begin
            data_q <= lane_data;
            hi_q   <= hi_en;
        end else begin
            data_q <= '0;
            hi_q   <= 1'b0;
        end
    end

    // output decode
    always_comb begin
        lane_lo_oe = 1'b0;
        lane_hi_oe = 1'b0;
        dout_valid = 1'b0;
        unique case (state_q)
            ST_DRIVE: begin
                lane_lo_oe = 1'b1;
                lane_hi_oe = hi_q;
                dout_valid = 1'b1;
            end
            ST_STANDBY, ST_ADDR_WAIT, ST_HOLE, ST_OE_WAIT: begin
                lane_lo_oe = 1'b0;
            end
            default: begin
                lane_lo_oe = 1'b0;
            end
        endcase
    end

    assign dout = data_q;

    // R2: chip enable inactive floats both lanes at the next edge
    p_ce_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_en_n) |-> (!lane_lo_oe && !lane_hi_oe));

    // R3: output enable inactive floats both lanes at the next edge
    p_oe_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_en_n) |-> (!lane_lo_oe && !lane_hi_oe));

    // R7: the unpopulated region never drives
    p_hole_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr[ADDR_W-1] && addr[ADDR_W-2]) |-> !lane_lo_oe);

    // R4: word reads drive both lanes
    p_word_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_lo_oe && $past(word_mode)) |-> lane_hi_oe);

    // R5: byte reads leave the upper lane floating and zero
    p_byte_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_lo_oe && !$past(word_mode)) |-> (!lane_hi_oe && dout[DATA_W-1:LANE_W] == '0));

    // R8: driving only once both counts have reached their limits
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_lo_oe |-> (acc_cnt == ACW'(ADDR_LAT) && oe_cnt == OCW'(OE_LAT)));

    // R12: floating bus reads as zero
    p_float_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_lo_oe |-> (dout == '0));

endmodule

// File: tb/rom_rw_port_bench.sv
module rom_rw_port_bench;

    localparam int AL   = 3;
    localparam int OL   = 2;
    localparam int SEED = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        word_mode = 1'b1;
    logic [20:0] addr = '0;
    logic        byte_sel = 1'b0;
    logic [15:0] dout;
    logic        lane_lo_oe, lane_hi_oe, dout_valid;

    always #10 clk = ~clk;   // 50 MHz

    rom_rw_port u_rom_rw_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en_n  (chip_en_n),
        .out_en_n   (out_en_n),
        .word_mode  (word_mode),
        .addr       (addr),
        .byte_sel   (byte_sel),
        .dout       (dout),
        .lane_lo_oe (lane_lo_oe),
        .lane_hi_oe (lane_hi_oe),
        .dout_valid (dout_valid)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    finished = 0;

    // behavioural reference
    int   m_acc = 0, m_oec = 0;
    longint m_key_prev = -1;
    logic [15:0] e_dout = '0;
    logic e_lo = 0, e_hi = 0;

    function automatic int word_of(int a);
        int hi = (a >> 16) & 31;
        return ((a & 16'hFFFF) ^ (hi << 11) ^ (hi << 6) ^ (hi << 1) ^ SEED) & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_oec = 0; m_key_prev = -1;
            e_lo = 0; e_hi = 0; e_dout = '0;
        end else begin
            longint key;
            bit drive, hole;
            int w;
            key = longint'(word_mode) * (64'd1 << 22) + longint'(addr) * 2
                  + ((word_mode == 1'b0) ? longint'(byte_sel) : 0);
            if (chip_en_n)             m_acc = 0;
            else if (key != m_key_prev) m_acc = 1;
            else if (m_acc < AL)        m_acc = m_acc + 1;
            m_key_prev = key;
            if (chip_en_n || out_en_n) m_oec = 0;
            else if (m_oec < OL)       m_oec = m_oec + 1;
            hole  = addr[20] && addr[19];
            drive = !chip_en_n && (m_acc == AL) && (m_oec == OL) && !hole;
            w = word_of(int'(addr));
            e_lo = drive;
            e_hi = drive && word_mode;
            if (!drive)        e_dout = '0;
            else if (word_mode) e_dout = w[15:0];
            else if (byte_sel)  e_dout = {8'h00, w[15:8]};
            else                e_dout = {8'h00, w[7:0]};
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, {16'h0, dout}, {16'h0, e_dout}, "dout");
            check(cur_req, {31'h0, lane_lo_oe}, {31'h0, e_lo}, "lane_lo_oe");
            check(cur_req, {31'h0, lane_hi_oe}, {31'h0, e_hi}, "lane_hi_oe");
            check("R12", {31'h0, dout_valid}, {31'h0, lane_lo_oe}, "valid vs low lane");
        end
    end

    task automatic drive_in(bit ce_n, bit oe_n, bit wm, int a, bit bs);
        @(negedge clk); #1;
        chip_en_n = ce_n; out_en_n = oe_n; word_mode = wm;
        addr = a[20:0]; byte_sel = bs;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // count edges until valid, starting from the edge after the last drive
    task automatic measure(string req, int exp_edges);
        int seen = -1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (dout_valid && seen < 0) seen = i;
        end
        check(req, seen, exp_edges, "edges to valid");
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", wd);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        check("R1", {16'h0, dout}, 32'h0, "dout in reset");
        check("R1", {29'h0, lane_lo_oe, lane_hi_oe, dout_valid}, 32'h0, "flags in reset");
        drive_in(1, 1, 1, 0, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1", {29'h0, lane_lo_oe, lane_hi_oe, dout_valid}, 32'h0, "flags after reset");

        // R8 / R4: word read from standby
        cur_req = "R4";
        drive_in(0, 0, 1, 21'h012345, 0);
        measure("R8", AL);
        check("R4", {16'h0, dout}, word_of(21'h012345), "word data");
        check("R11", {16'h0, dout}, word_of(21'h012345), "contents formula");

        // R5 / R6: byte reads
        cur_req = "R5";
        drive_in(0, 0, 0, 21'h0ABCDE, 0);
        wait_cyc(6);
        check("R5", {16'h0, dout}, {24'h0, 8'(word_of(21'h0ABCDE))}, "low byte");
        cur_req = "R6";
        drive_in(0, 0, 0, 21'h0ABCDE, 1);
        wait_cyc(6);
        check("R6", {16'h0, dout}, {24'h0, 8'(word_of(21'h0ABCDE) >> 8)}, "high byte");
        check("R6", {31'h0, lane_hi_oe}, 32'h0, "upper lane floats");

        // R10: byte_sel ignored in word mode
        cur_req = "R10";
        drive_in(0, 0, 1, 21'h155555, 0);
        wait_cyc(5);
        for (int i = 0; i < 4; i++) begin
            drive_in(0, 0, 1, 21'h155555, (i % 2) == 0);
            check("R10", {31'h0, dout_valid}, 32'h1, "valid during toggle");
            check("R10", {16'h0, dout}, word_of(21'h155555), "data during toggle");
        end

        // R9: address change while driving
        cur_req = "R9";
        drive_in(0, 0, 1, 21'h000777, 0);
        wait_cyc(1);
        check("R9", {31'h0, lane_lo_oe}, 32'h0, "float after change");
        wait_cyc(5);
        drive_in(0, 0, 0, 21'h000777, 0);
        measure("R9", AL);
        drive_in(0, 0, 0, 21'h000777, 1);
        measure("R9", AL);

        // R7: unpopulated region in both modes, and the last populated word
        cur_req = "R7";
        drive_in(0, 0, 1, 21'h180000, 0);
        wait_cyc(6);
        check("R7", {30'h0, lane_lo_oe, dout_valid}, 32'h0, "hole word mode");
        drive_in(0, 0, 0, 21'h1FFFFF, 1);
        wait_cyc(6);
        check("R7", {30'h0, lane_lo_oe, dout_valid}, 32'h0, "hole byte mode");
        cur_req = "R11";
        drive_in(0, 0, 1, 21'h17FFFF, 0);
        wait_cyc(6);
        check("R11", {16'h0, dout}, word_of(21'h17FFFF), "top populated word");

        // R3: output enable dropped mid access, then late output enable
        cur_req = "R3";
        drive_in(0, 1, 1, 21'h17FFFF, 0);
        wait_cyc(1);
        check("R3", {30'h0, lane_lo_oe, lane_hi_oe}, 32'h0, "float one edge after oe");
        wait_cyc(4);
        cur_req = "R8";
        drive_in(0, 0, 1, 21'h17FFFF, 0);
        measure("R8", OL);

        // R2: chip enable dropped mid access
        cur_req = "R2";
        drive_in(1, 0, 1, 21'h17FFFF, 0);
        wait_cyc(1);
        check("R2", {30'h0, lane_lo_oe, lane_hi_oe}, 32'h0, "float one edge after ce");
        drive_in(0, 0, 1, 21'h0000FF, 0);
        wait_cyc(1);
        drive_in(1, 0, 1, 21'h0000FF, 0);
        wait_cyc(4);
        check("R2", {31'h0, dout_valid}, 32'h0, "interrupted access stays idle");

        // R11: sweep of addresses
        cur_req = "R11";
        for (int i = 0; i < 8; i++) begin
            int a = (i * 21'h02F3B1) % 21'h180000;
            drive_in(0, 0, 1, a, 0);
            wait_cyc(4);
            check("R11", {16'h0, dout}, word_of(a), "sweep word");
        end

        drive_in(1, 1, 1, 0, 0);
        wait_cyc(2);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule